// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block collects a bank of external interrupt lines and delivers them to a small set of processor cores. Each source line is brought into the clock domain through a two-flop synchroniser and is then interpreted according to its own sense settings: active level (high or low), single edge (rising or falling), or both edges. Edge-sensed sources capture a sticky pending bit. Level-sensed sources report pending directly from the synchronised, polarity-corrected input.

Software configures the block over a simple 32-bit register bus with a write strobe and a combinational read path. The enable mask has no direct-write path. It changes only through a write-1-to-set register and a write-1-to-clear register, so separate agents can enable and disable different sources without a read-modify-write. A single write-only edge command register takes a source index and a set/clear flag. Set injects a pending edge, which is how inter-processor interrupts are raised. Clear acknowledges a captured edge. Every source carries a core-select field. Each core has one interrupt output, raised while any source that targets it is both pending and enabled.

Top module: `irqsrc_bank`

## Requirements
- R1: After reset every source is active-high, level-sensed, single-edge, disabled and routed to core 0. The sense, pending and enable words and the core-select fields all read 0, and all core outputs are low.
- R2: A write to the enable-set word w (address 0x100 + 4w) sets the enable bit of source 32w+b for every 1 in data bit b. Bits written as 0 leave their enable bits unchanged.
- R3: A write to the enable-clear word w (address 0x140 + 4w) clears the enable bit of source 32w+b for every 1 in data bit b. Bits written as 0 leave their enable bits unchanged.
- R4: A level-sensed source (trigger bit 0) reads pending when its synchronised input is 1 with polarity bit 0, or 0 with polarity bit 1. An edge command aimed at a level-sensed source has no effect on its pending bit.
- R5: An edge-sensed source (trigger bit 1, both-edges bit 0) latches pending on a rising input edge when its polarity bit is 0, or on a falling edge when its polarity bit is 1. The bit stays pending after the input returns.
- R6: An edge-sensed source with its both-edges bit set latches pending on either input edge, whatever its polarity bit holds.
- R7: A write to the edge command register (address 0x010) addresses source index data[6:0]. With data[31]=1 it sets that source's edge-pending bit; with data[31]=0 it clears it. A detected input edge in the same cycle as a clear wins.
- R8: Core output c is 1 exactly when some source is pending, enabled and has core-select field equal to c. Rewriting a core-select field moves the source to the new core.
- R9: The pending word w reads at 0x180 + 4w and the enable word w at 0x1C0 + 4w. Bit b gives source 32w+b, and bits beyond the last source read 0.
- R10: The read-only configuration word at 0x000 holds (sources/8 − 1) in bits [23:16] and (cores − 1) in bits [7:0]. All other bits read 0.
- R11: The sense words read back as written: polarity at 0x040 + 4w (1 = active low / falling), trigger at 0x080 + 4w (1 = edge), both-edges at 0x0C0 + 4w. The core-select field of source i sits at 0x200 + 4i in bits [CORE_W-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Asynchronous interrupt source lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 10 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| core_irq_o | output | NUM_CORE | One interrupt request per core |

## Verification
The assertions watch the enable-set and enable-clear writes on every cycle: the enable bits hit by ones change, and those hit by zeros hold. They also check that the enables are cleared after reset and that no core output is raised without at least as many pending, enabled sources behind it. Sense-mode behaviour can only be shown by the bench's scenarios, since it depends on the input history across the synchroniser. These cover each level and edge mode, edge injection and acknowledgement on edge and level sources, and moving a source between cores. Random sequences are compared against a bench-side model of the pending bits.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;

   localparam int unsigned BUS_W  = 32;
   localparam int unsigned ADDR_W = 10;
   localparam int unsigned IDX_W  = 7;

   // Register region picked by address bits [8:6] when bit 9 is clear
   typedef enum logic [2:0] {
      RG_MISC = 3'd0,
      RG_POL  = 3'd1,
      RG_TRIG = 3'd2,
      RG_DUAL = 3'd3,
      RG_MSET = 3'd4,
      RG_MCLR = 3'd5,
      RG_PEND = 3'd6,
      RG_MASK = 3'd7
   } region_e;

   localparam logic [3:0] CFG_WORD  = 4'd0;
   localparam logic [3:0] EDGE_WORD = 4'd4;
   localparam int unsigned EDGE_SET_BIT = 31;

   function automatic int unsigned idx_w(int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/irqsrc_sync.sv
module irqsrc_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irqsrc_sync needs at least two stages");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) stage_q[s] <= '0;
         else if (s == 0) stage_q[s] <= d_i;
         else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/irqsrc_sense.sv
module irqsrc_sense #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] sync_i,
   input  logic [N-1:0] pol_i,
   input  logic [N-1:0] trig_i,
   input  logic [N-1:0] dual_i,
   input  logic [N-1:0] sw_set_i,
   input  logic [N-1:0] sw_clr_i,
   output logic [N-1:0] pend_o
);

   logic [N-1:0] prev_q;
   logic [N-1:0] latch_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= '0;
      else prev_q <= sync_i;
   end

   for (genvar g = 0; g < N; g++) begin : g_src
      logic active, active_prev, one_edge, any_edge, hit;

      always_comb begin
         active      = sync_i[g] ^ pol_i[g];
         active_prev = prev_q[g] ^ pol_i[g];
         one_edge    = active & ~active_prev;
         any_edge    = sync_i[g] ^ prev_q[g];
         hit         = dual_i[g] ? any_edge : one_edge;
      end

      always_ff @(posedge clk) begin
         if (rst || !trig_i[g]) latch_q[g] <= 1'b0;
         else if (hit || sw_set_i[g]) latch_q[g] <= 1'b1;
         else if (sw_clr_i[g]) latch_q[g] <= 1'b0;
      end

      assign pend_o[g] = trig_i[g] ? latch_q[g] : active;
   end

endmodule

// File: rtl/irqsrc_route.sv
module irqsrc_route #(
   parameter int unsigned N  = 8,
   parameter int unsigned C  = 2,
   parameter int unsigned CW = 1
) (
   input  logic [N-1:0]    pend_i,
   input  logic [N-1:0]    mask_i,
   input  logic [N*CW-1:0] map_i,
   output logic [C-1:0]    core_o
);

   for (genvar c = 0; c < C; c++) begin : g_core
      always_comb begin
         core_o[c] = 1'b0;
         for (int i = 0; i < N; i++) begin
            if (pend_i[i] && mask_i[i] && (map_i[i*CW +: CW] == CW'(c)))
               core_o[c] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/irqsrc_bank.sv
module irqsrc_bank
   import irqsrc_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 40,
   parameter int unsigned NUM_CORE = 4,
   parameter int unsigned SYNC_STG = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_SRC-1:0]  src_i,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [BUS_W-1:0]    bus_wdata,
   output logic [BUS_W-1:0]    bus_rdata,
   output logic [NUM_CORE-1:0] core_irq_o
);

   localparam int unsigned CORE_W  = idx_w(NUM_CORE);
   localparam int unsigned GRP_M1  = NUM_SRC / 8 - 1;
   localparam int unsigned CORE_M1 = NUM_CORE - 1;

   if ((NUM_SRC % 8) != 0 || NUM_SRC < 8 || NUM_SRC > 128) begin : g_bad_src
      $error("NUM_SRC must be a multiple of 8 between 8 and 128");
   end
   if (NUM_CORE < 1 || NUM_CORE > 256) begin : g_bad_core
      $error("NUM_CORE must be between 1 and 256");
   end

   // Address decode
   logic             map_sel;
   region_e          region;
   logic [3:0]       wsel;
   logic [IDX_W-1:0] map_idx;
   logic             unused_addr_bits;

   assign map_sel          = bus_addr[9];
   assign region           = region_e'(bus_addr[8:6]);
   assign wsel             = bus_addr[5:2];
   assign map_idx          = bus_addr[8:2];
   assign unused_addr_bits = ^bus_addr[1:0];

   // Configuration state
   logic [NUM_SRC-1:0]        pol_q, trig_q, dual_q, mask_q;
   logic [NUM_SRC*CORE_W-1:0] map_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pol_q  <= '0;
         trig_q <= '0;
         dual_q <= '0;
         mask_q <= '0;
         map_q  <= '0;
      end else if (bus_we && !map_sel) begin
         for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(wsel) == i / 32) begin
               case (region)
                  RG_POL:  pol_q[i]  <= bus_wdata[i % 32];
                  RG_TRIG: trig_q[i] <= bus_wdata[i % 32];
                  RG_DUAL: dual_q[i] <= bus_wdata[i % 32];
                  RG_MSET: if (bus_wdata[i % 32]) mask_q[i] <= 1'b1;
                  RG_MCLR: if (bus_wdata[i % 32]) mask_q[i] <= 1'b0;
                  default: ;
               endcase
            end
         end
      end else if (bus_we && map_sel) begin
         for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(map_idx) == i) map_q[i*CORE_W +: CORE_W] <= bus_wdata[CORE_W-1:0];
         end
      end
   end

   // Edge command decode
   logic               edge_wr;
   logic [NUM_SRC-1:0] sw_set, sw_clr;

   assign edge_wr = bus_we && !map_sel && (region == RG_MISC) && (wsel == EDGE_WORD);

   always_comb begin
      for (int i = 0; i < NUM_SRC; i++) begin
         sw_set[i] = edge_wr && (bus_wdata[IDX_W-1:0] == IDX_W'(i)) &&  bus_wdata[EDGE_SET_BIT];
         sw_clr[i] = edge_wr && (bus_wdata[IDX_W-1:0] == IDX_W'(i)) && !bus_wdata[EDGE_SET_BIT];
      end
   end

   // Datapath
   logic [NUM_SRC-1:0] sync_src, pend;

   irqsrc_sync #(.W(NUM_SRC), .STAGES(SYNC_STG)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (src_i),
      .q_o (sync_src)
   );

   irqsrc_sense #(.N(NUM_SRC)) u_sense (
      .clk      (clk),
      .rst      (rst),
      .sync_i   (sync_src),
      .pol_i    (pol_q),
      .trig_i   (trig_q),
      .dual_i   (dual_q),
      .sw_set_i (sw_set),
      .sw_clr_i (sw_clr),
      .pend_o   (pend)
   );

   irqsrc_route #(.N(NUM_SRC), .C(NUM_CORE), .CW(CORE_W)) u_route (
      .pend_i (pend),
      .mask_i (mask_q),
      .map_i  (map_q),
      .core_o (core_irq_o)
   );

   // Read path
   function automatic logic [BUS_W-1:0] word_of(input logic [NUM_SRC-1:0] v, input logic [3:0] w);
      logic [BUS_W-1:0] r;
      r = '0;
      for (int b = 0; b < 32; b++) begin
         if (int'(w) * 32 + b < NUM_SRC) r[b] = v[int'(w) * 32 + b];
      end
      return r;
   endfunction

   always_comb begin
      bus_rdata = '0;
      if (map_sel) begin
         for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(map_idx) == i) bus_rdata[CORE_W-1:0] = map_q[i*CORE_W +: CORE_W];
         end
      end else begin
         case (region)
            RG_MISC: if (wsel == CFG_WORD) begin
               bus_rdata[23:16] = 8'(GRP_M1);
               bus_rdata[7:0]   = 8'(CORE_M1);
            end
            RG_POL:  bus_rdata = word_of(pol_q, wsel);
            RG_TRIG: bus_rdata = word_of(trig_q, wsel);
            RG_DUAL: bus_rdata = word_of(dual_q, wsel);
            RG_PEND: bus_rdata = word_of(pend, wsel);
            RG_MASK: bus_rdata = word_of(mask_q, wsel);
            default: bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/irqsrc_bank_chk.sv
module irqsrc_bank_chk
   import irqsrc_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 40,
   parameter int unsigned NUM_CORE = 4
) (
   input logic                clk,
   input logic                rst,
   input logic                bus_we,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [BUS_W-1:0]    bus_wdata,
   input logic [NUM_SRC-1:0]  mask_q,
   input logic [NUM_SRC-1:0]  pend,
   input logic [NUM_CORE-1:0] core_irq_o
);

   localparam int unsigned W0 = (NUM_SRC < 32) ? NUM_SRC : 32;
   localparam logic [ADDR_W-1:0] MSET0 = 10'h100;
   localparam logic [ADDR_W-1:0] MCLR0 = 10'h140;

   // R1
   reset_mask_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (mask_q == '0));

   // R2
   mask_set_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == MSET0) |=>
      ((mask_q[W0-1:0] & $past(bus_wdata[W0-1:0])) == $past(bus_wdata[W0-1:0])));

   // R2
   mask_set_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == MSET0) |=>
      ((mask_q[W0-1:0] & ~$past(bus_wdata[W0-1:0])) == ($past(mask_q[W0-1:0]) & ~$past(bus_wdata[W0-1:0]))));

   // R3
   mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == MCLR0) |=>
      ((mask_q[W0-1:0] & $past(bus_wdata[W0-1:0])) == '0));

   // R3
   mask_clr_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == MCLR0) |=>
      ((mask_q[W0-1:0] & ~$past(bus_wdata[W0-1:0])) == ($past(mask_q[W0-1:0]) & ~$past(bus_wdata[W0-1:0]))));

   // R8
   core_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(core_irq_o) <= $countones(pend & mask_q));

endmodule

bind irqsrc_bank irqsrc_bank_chk #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .mask_q     (mask_q),
   .pend       (pend),
   .core_irq_o (core_irq_o)
);

// File: tb/tb_irqsrc_bank.sv
`timescale 1ns/1ps
module tb_irqsrc_bank;

   localparam int NS = 40;
   localparam int NC = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NS-1:0] src_i = '0;
   logic          bus_we = 1'b0;
   logic [9:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NC-1:0] core_irq_o;

   always #4 clk = ~clk;

   irqsrc_bank #(.NUM_SRC(NS), .NUM_CORE(NC)) dut (
      .clk(clk), .rst(rst), .src_i(src_i), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_irq_o(core_irq_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // Bench model
   logic [NS-1:0] m_pol = '0, m_trig = '0, m_dual = '0, m_mask = '0, m_ep = '0, m_in = '0;
   int m_map [NS];

   function automatic logic [31:0] word(input logic [NS-1:0] v, input int w);
      logic [NS-1:0] t;
      t = v >> (32 * w);
      return (w == 0) ? t[31:0] : {24'h0, t[7:0]};
   endfunction

   function automatic logic [NS-1:0] exp_pend();
      logic [NS-1:0] p;
      for (int i = 0; i < NS; i++) p[i] = m_trig[i] ? m_ep[i] : (m_in[i] ^ m_pol[i]);
      return p;
   endfunction

   function automatic logic [NC-1:0] exp_core();
      logic [NC-1:0] c;
      logic [NS-1:0] p;
      p = exp_pend();
      c = '0;
      for (int i = 0; i < NS; i++) if (p[i] && m_mask[i]) c[m_map[i]] = 1'b1;
      return c;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic check_status(input string tag);
      logic [31:0] d;
      for (int w = 0; w < 2; w++) begin
         rd(10'h180 + 10'(4 * w), d);
         check({tag, " R9 pend"}, d, word(exp_pend(), w));
         rd(10'h1C0 + 10'(4 * w), d);
         check({tag, " R9 mask"}, d, word(m_mask, w));
      end
      check({tag, " R8 core"}, 32'(core_irq_o), 32'(exp_core()));
   endtask

   task automatic set_input(input int i, input logic v);
      logic old;
      old = m_in[i];
      @(negedge clk);
      src_i[i] = v;
      m_in[i] = v;
      if (m_trig[i] && old != v) begin
         if (m_dual[i]) m_ep[i] = 1'b1;
         else if ((!m_pol[i] && v) || (m_pol[i] && !v)) m_ep[i] = 1'b1;
      end
      settle();
   endtask

   task automatic mask_set(input int w, input logic [31:0] d);
      wr(10'h100 + 10'(4 * w), d);
      for (int b = 0; b < 32; b++) if (32 * w + b < NS && d[b]) m_mask[32 * w + b] = 1'b1;
      settle();
   endtask

   task automatic mask_clr(input int w, input logic [31:0] d);
      wr(10'h140 + 10'(4 * w), d);
      for (int b = 0; b < 32; b++) if (32 * w + b < NS && d[b]) m_mask[32 * w + b] = 1'b0;
      settle();
   endtask

   task automatic edge_cmd(input int i, input logic set);
      wr(10'h010, {set, 24'h0, 7'(i)});
      if (m_trig[i]) m_ep[i] = set;
      settle();
   endtask

   task automatic set_map(input int i, input int c);
      wr(10'h200 + 10'(4 * i), 32'(c));
      m_map[i] = c;
      settle();
   endtask

   // kind: 0 polarity, 1 trigger, 2 both-edges
   task automatic set_mode(input int kind, input int i, input logic v);
      int w;
      w = i / 32;
      case (kind)
         0: begin m_pol[i] = v;  wr(10'h040 + 10'(4 * w), word(m_pol, w));  end
         1: begin m_trig[i] = v; if (!v) m_ep[i] = 1'b0; wr(10'h080 + 10'(4 * w), word(m_trig, w)); end
         default: begin m_dual[i] = v; wr(10'h0C0 + 10'(4 * w), word(m_dual, w)); end
      endcase
      settle();
   endtask

   initial begin
      logic [31:0] d;
      int unsigned r;
      for (int i = 0; i < NS; i++) m_map[i] = 0;
      r = $urandom(32'h1234_5678);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      settle();

      // R1 / R10 reset and configuration word
      rd(10'h000, d); check("R10 cfg", d, 32'h0004_0003);
      rd(10'h040, d); check("R1 pol", d, 32'h0);
      rd(10'h080, d); check("R1 trig", d, 32'h0);
      rd(10'h0C0, d); check("R1 dual", d, 32'h0);
      rd(10'h200 + 10'd20, d); check("R1 map", d, 32'h0);
      check("R1 core", 32'(core_irq_o), 32'h0);
      check_status("R1");

      // R2 set and R4 level high
      mask_set(0, 32'h0000_0009);
      rd(10'h1C0, d); check("R2 set", d, 32'h0000_0009);
      mask_set(0, 32'h0000_0010);
      rd(10'h1C0, d); check("R2 keep", d, 32'h0000_0019);
      set_input(3, 1'b1);
      check("R4 level high", 32'(core_irq_o), 32'h1);
      check_status("R4");
      // R4 edge command on level source ignored
      edge_cmd(3, 1'b0);
      check("R4 clr ignored", 32'(core_irq_o), 32'h1);
      edge_cmd(4, 1'b1);
      rd(10'h180, d); check("R4 set ignored", d, 32'h0000_0008);
      // R4 active low
      set_mode(0, 3, 1'b1);
      check("R4 low pol idle", 32'(core_irq_o), 32'h0);
      set_input(3, 1'b0);
      check("R4 low pol active", 32'(core_irq_o), 32'h1);
      // R3 clear
      mask_clr(0, 32'h0000_0008);
      rd(10'h1C0, d); check("R3 clr", d, 32'h0000_0011);
      check("R3 core off", 32'(core_irq_o), 32'h0);
      mask_set(0, 32'h0000_0008);
      set_mode(0, 3, 1'b0);

      // R5 rising edge on source 0
      set_mode(1, 0, 1'b1);
      set_input(0, 1'b1);
      set_input(0, 1'b0);
      rd(10'h180, d); check("R5 rise held", d & 32'h1, 32'h1);
      edge_cmd(0, 1'b0);
      rd(10'h180, d); check("R7 ack", d & 32'h1, 32'h0);
      // R5 falling edge
      set_mode(0, 0, 1'b1);
      set_input(0, 1'b1);
      rd(10'h180, d); check("R5 no fall on rise", d & 32'h1, 32'h0);
      set_input(0, 1'b0);
      rd(10'h180, d); check("R5 fall", d & 32'h1, 32'h1);
      edge_cmd(0, 1'b0);
      // R6 both edges, polarity ignored
      set_mode(2, 0, 1'b1);
      set_input(0, 1'b1);
      rd(10'h180, d); check("R6 rise", d & 32'h1, 32'h1);
      edge_cmd(0, 1'b0);
      set_input(0, 1'b0);
      rd(10'h180, d); check("R6 fall", d & 32'h1, 32'h1);
      edge_cmd(0, 1'b0);
      // R7 injection
      edge_cmd(0, 1'b1);
      check("R7 inject", 32'(core_irq_o), 32'h1);
      // R8 rerouting
      set_map(0, 2);
      check("R8 moved", 32'(core_irq_o), 32'h4);
      rd(10'h200, d); check("R11 map", d, 32'h2);
      rd(10'h080, d); check("R11 trig", d, 32'h1);
      rd(10'h0C0, d); check("R11 dual", d, 32'h1);
      rd(10'h040, d); check("R11 pol", d, 32'h1);
      // R9 second word, source 35
      mask_set(1, 32'h0000_0008);
      set_map(35, 3);
      set_input(35, 1'b1);
      rd(10'h184, d); check("R9 word1 pend", d, 32'h0000_0008);
      rd(10'h1C4, d); check("R9 word1 mask", d, 32'h0000_0008);
      check_status("R8 directed");

      // Random phase
      for (int k = 0; k < 300; k++) begin
         int op, i;
         op = int'($urandom % 9);
         i  = int'($urandom % NS);
         case (op)
            0, 1, 2: set_input(i, ~m_in[i]);
            3: mask_set(int'($urandom % 2), $urandom);
            4: mask_clr(int'($urandom % 2), $urandom);
            5: edge_cmd(i, 1'($urandom));
            6: set_map(i, int'($urandom % NC));
            default: set_mode(int'($urandom % 3), i, 1'($urandom));
         endcase
         check_status("R5 R6 R7 random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule